// File: doc/BRIEF.md
# Factorial Coprocessor

This block is a small memory-mapped compute unit that produces n! for a 32-bit operand n. The host writes n into a single data register. Accepting the operand raises a busy flag in the status word, and a sequential datapath then multiplies once per clock. When the work ends, the product replaces the operand in that same data register and the busy flag drops.

A status bit that software can write enables a completion request. When that bit is set, the block raises a one-cycle request, with interrupt bit 0 set, towards an external interrupt status block.

The register port is a plain strobe interface with a combinational read path, so there is no back-pressure. A write is taken in the cycle where `reg_wr` is high. A read has no side effects, and `reg_rdata` follows `reg_addr` and `reg_full32` in the same cycle. Software waits on the busy flag or on the completion request before it reads the result.

Top module: `fact_copro`

## Requirements
- R1: The data register sits at byte offset 0x08 and the status register at byte offset 0x20. A full-width status read returns busy in bit 0, the interrupt enable in bit 7, and zeros in all other bits. A full-width read of any other offset returns 0.
- R2: A full-width write to 0x08 while busy is 0 stores the operand and sets busy from the next cycle. Reads of 0x08 while busy return that operand.
- R3: A write to 0x08 while busy is 1 is discarded. It does not change the data register and does not restart or lengthen the computation. This also holds for a write in the last busy cycle.
- R4: The result is n·(n−1)·…·1 truncated to 32 bits. Operands 0 and 1 give 1.
- R5: After an accepted operand n, busy reads 1 for exactly max(n,1) cycles. The result is readable in the first cycle in which busy reads 0.
- R6: A full-width write to 0x20 sets the interrupt enable to bit 7 of the written data. No status write changes busy.
- R7: When a computation ends with the enable set, `irq_set` equals 0x00000001 for exactly one cycle, which is the first cycle in which busy reads 0. With the enable clear, `irq_set` stays 0.
- R8: A write with `reg_full32` low has no effect. A read with `reg_full32` low returns 0xFFFFFFFF.
- R9: A synchronous active-high reset clears busy, the interrupt enable, the data register and `irq_set`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe, taken in the cycle it is high |
| reg_addr | input | 8 | Byte offset of the access |
| reg_full32 | input | 1 | High when the access is 32 bits wide |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_set | output | 32 | Interrupt bits to set, one-cycle pulse on completion |

## Verification
The delicate coincidence is a host operand write arriving in the same cycle as completion. In that cycle busy still reads 1, so the write must be dropped while the result lands in the data register. The bench places such writes at a randomly chosen busy cycle, including the final one. It then checks that the busy length still equals max(n,1), that the data register holds n! and not the injected value, and that the completion pulse appears exactly once.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_DATA = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_IEN_BIT  = 7;
  localparam logic [DATA_W-1:0] DONE_IRQ_MASK = 32'h0000_0001;
endpackage

// File: rtl/fcp_mul_engine.sv
module fcp_mul_engine #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] operand,
  output logic         running,
  output logic         done,
  output logic [W-1:0] result
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] acc_q;
  logic         run_q;
  logic         last;

  assign last    = (cnt_q <= W'(1));
  assign done    = run_q && last;
  assign running = run_q;
  assign result  = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      acc_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= operand;
      acc_q <= W'(1);
    end else if (run_q) begin
      if (last) begin
        run_q <= 1'b0;
      end else begin
        acc_q <= acc_q * cnt_q;
        cnt_q <= cnt_q - W'(1);
      end
    end
  end

  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !run_q);
  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !last && !start) |=> (cnt_q == $past(cnt_q) - W'(1)));
  // R5
  done_ends_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !run_q);
endmodule

// File: rtl/fcp_regs.sv
module fcp_regs
  import fcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_full32,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] irq_set,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_result,
  output logic              eng_start,
  output logic [DATA_W-1:0] eng_operand,
  output logic              busy
);
  logic [DATA_W-1:0] data_q;
  logic              busy_q;
  logic              ien_q;
  logic              irq_q;
  logic              wr_ok;
  logic [DATA_W-1:0] stat_word;

  assign wr_ok       = reg_wr && reg_full32;
  assign eng_start   = wr_ok && (reg_addr == OFS_DATA) && !busy_q;
  assign eng_operand = reg_wdata;
  assign busy        = busy_q;
  assign irq_set     = irq_q ? DONE_IRQ_MASK : '0;

  always_comb begin
    stat_word = '0;
    stat_word[STAT_BUSY_BIT] = busy_q;
    stat_word[STAT_IEN_BIT]  = ien_q;
  end

  always_comb begin
    if (!reg_full32) begin
      reg_rdata = '1;
    end else begin
      case (reg_addr)
        OFS_DATA: reg_rdata = data_q;
        OFS_STAT: reg_rdata = stat_word;
        default:  reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      busy_q <= 1'b0;
      ien_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (eng_start) begin
        data_q <= reg_wdata;
        busy_q <= 1'b1;
      end else if (eng_done) begin
        data_q <= eng_result;
        busy_q <= 1'b0;
      end
      if (wr_ok && (reg_addr == OFS_STAT)) begin
        ien_q <= reg_wdata[STAT_IEN_BIT];
      end
      irq_q <= eng_done && ien_q;
    end
  end

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(reg_wr && reg_full32 && (reg_addr == OFS_DATA)));
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !eng_done) |=> $stable(data_q));
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> !busy_q);
  // R1
  stat_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_full32 && reg_addr == OFS_STAT) |-> (reg_rdata[6:1] == '0));
endmodule

// File: rtl/fact_copro.sv
module fact_copro (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic        reg_full32,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [31:0] irq_set
);
  import fcp_pkg::*;

  logic              start;
  logic [DATA_W-1:0] operand;
  logic              running;
  logic              done;
  logic [DATA_W-1:0] result;
  logic              busy;

  fcp_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_full32 (reg_full32),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_set    (irq_set),
    .eng_done   (done),
    .eng_result (result),
    .eng_start  (start),
    .eng_operand(operand),
    .busy       (busy)
  );

  fcp_mul_engine #(.W(DATA_W)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .operand (operand),
    .running (running),
    .done    (done),
    .result  (result)
  );

  // R5
  busy_match_chk: assert property (@(posedge clk) disable iff (rst)
    busy == running);
endmodule

// File: tb/sim_fact_copro.sv
module sim_fact_copro;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_full32 = 1'b1;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] irq_set;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit ended  = 0;

  localparam logic [7:0] A_DATA = 8'h08;
  localparam logic [7:0] A_STAT = 8'h20;

  fact_copro u0 (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] fact(input int n);
    logic [31:0] r = 32'd1;
    for (int i = 2; i <= n; i++) r = r * 32'(i);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic full);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_full32 = full;
    @(negedge clk);
    reg_wr = 1'b0; reg_full32 = 1'b1;
  endtask

  function automatic logic [31:0] rd_now(input logic [7:0] a);
    return 32'h0;
  endfunction

  task automatic rd(input logic [7:0] a, input logic full, output logic [31:0] d);
    reg_addr = a; reg_full32 = full;
    #1 d = reg_rdata;
    reg_full32 = 1'b1;
  endtask

  // Runs one computation; inject>0 puts a discarded operand write in that busy cycle.
  task automatic run_op(input int n, input bit ien, input int inject);
    logic [31:0] v;
    int cyc = 0;
    int exp_len = (n < 1) ? 1 : n;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_DATA; reg_wdata = 32'(n); reg_full32 = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    forever begin
      reg_wr = 1'b0;
      rd(A_STAT, 1'b1, v);
      if (!v[0] || cyc > 5000) break;
      cyc++;
      if (cyc == 1) begin
        rd(A_DATA, 1'b1, v);
        chk("R2 operand readable while busy", v, 32'(n));
        chk("R7 no request while busy", irq_set, 32'h0);
      end
      if (cyc == inject) begin
        reg_wr = 1'b1; reg_addr = A_DATA; reg_wdata = 32'hDEAD_0000 + 32'(n);
      end
      @(negedge clk);
    end
    chk("R5 busy length", 32'(cyc), 32'(exp_len));
    chk("R3/R7 completion request", irq_set, ien ? 32'h1 : 32'h0);
    rd(A_DATA, 1'b1, v);
    chk("R4 result", v, fact(n));
    @(negedge clk);
    chk("R7 request is one cycle", irq_set, 32'h0);
    rd(A_STAT, 1'b1, v);
    chk("R3 no restart after dropped write", v, {24'h0, ien, 7'h0});
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    rd(A_STAT, 1'b1, v); chk("R9 status after reset", v, 32'h0);
    rd(A_DATA, 1'b1, v); chk("R9 data after reset", v, 32'h0);
    chk("R9 irq after reset", irq_set, 32'h0);
    // R1 unmapped read
    rd(8'h40, 1'b1, v); chk("R1 unmapped read", v, 32'h0);
    // R8 narrow access
    rd(A_DATA, 1'b0, v); chk("R8 narrow read", v, 32'hFFFF_FFFF);
    wr(A_DATA, 32'd5, 1'b0);
    rd(A_STAT, 1'b1, v); chk("R8 narrow write no start", v, 32'h0);
    rd(A_DATA, 1'b1, v); chk("R8 narrow write no data", v, 32'h0);
    wr(A_STAT, 32'hFF, 1'b0);
    rd(A_STAT, 1'b1, v); chk("R8 narrow status write", v, 32'h0);
    // R6 status writes
    wr(A_STAT, 32'h0000_0001, 1'b1);
    rd(A_STAT, 1'b1, v); chk("R6 bit0 write no busy", v, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF, 1'b1);
    rd(A_STAT, 1'b1, v); chk("R6 enable set, R1 layout", v, 32'h80);
    wr(A_STAT, 32'hFFFF_FF7F, 1'b1);
    rd(A_STAT, 1'b1, v); chk("R6 enable clear", v, 32'h0);
    // directed computations
    run_op(0, 1'b0, 0);
    wr(A_STAT, 32'h80, 1'b1);
    run_op(1, 1'b1, 0);
    run_op(12, 1'b1, 0);
    run_op(13, 1'b1, 13);
    run_op(34, 1'b1, 5);
    wr(A_STAT, 32'h00, 1'b1);
    run_op(7, 1'b0, 7);
    // random computations
    for (int k = 0; k < 25; k++) begin
      int n = int'($urandom % 40);
      bit e = 1'($urandom);
      int inj = (n < 1) ? int'($urandom % 2) : int'($urandom % (n + 1));
      wr(A_STAT, e ? 32'h80 : 32'h0, 1'b1);
      run_op(n, e, inj);
    end
    // R9 reset mid-computation
    wr(A_STAT, 32'h80, 1'b1);
    wr(A_DATA, 32'd20, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(A_STAT, 1'b1, v); chk("R9 status after mid reset", v, 32'h0);
    rd(A_DATA, 1'b1, v); chk("R9 data after mid reset", v, 32'h0);
    finish_run();
  end
endmodule